// File: doc/BRIEF.md
# Self-Calibrating Echo Responder

This block is one side of a two-node trigger exchange. Each time a peer trigger arrives, already stamped by a capture stage, the block schedules its own outgoing trigger a fixed number of ticks later. The outgoing pulse is sent back through the same capture stage. The stamp of that pulse shows how late the emission really was. That lateness, bounded to a configured magnitude, is subtracted from the next scheduled emission. As a result, a steady scheduling overhead is cancelled out over later iterations.

The block also keeps the stamp of the first peer trigger of a session and counts the peer triggers that follow. When the configured count is reached, it reports the local timing error. This error is the measured span minus the ideal span of two reply delays per iteration. It also reports a drift estimate toward the peer, equal to twice that error. No timestamps are exchanged with the peer. All arithmetic on ticks is modulo the timestamp width, so a wrapping tick counter is handled.

Top module: `echo_responder`

## Requirements
- R1: After reset, `trig_out`, `done`, `err_out` and `drift_out` are 0. The block is idle, and peer triggers give no response until `start` has been seen.
- R2: A cycle with `start` high clears the iteration count, the first-trigger record, the compensation value, any pending or awaited emission, `err_out` and `done`. It opens a session, and `start` takes priority over any other input in that cycle.
- R3: An accepted peer trigger with stamp S sets the target T = S + `cfg_delay` − C, where C is the current compensation value. `trig_out` goes high for one cycle right after the first later clock edge at which `now` − T, read as a signed TS_W-bit number, is not negative.
- R4: `trig_out` is never high for two cycles in a row. A peer trigger accepted while an emission is still pending replaces its target, so only one pulse results.
- R5: A `lb_valid` stamp L that arrives after an emission and before the next loopback sets C = L − T of that emission. C is clamped to the range −`cfg_comp_lim` to +`cfg_comp_lim`. A `lb_valid` with no emission awaiting its loopback is ignored.
- R6: The first accepted trigger of a session is stored as the reference, and it is still echoed. When the k-th trigger after it, where k = `cfg_iters` (at least 1), is accepted, `done` is high for one cycle. That trigger is not echoed, and later triggers are ignored until the next `start`.
- R7: On completion, `err_out` = (S_last − S_first − 2·`cfg_iters`·`cfg_delay`) modulo 2^TS_W, read as signed, and `drift_out` = 2·`err_out`. Both outputs hold their values until the next completion or `start`.
- R8: Targets and comparisons work across a wrap of the tick counter `now`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new measurement session |
| cfg_delay | input | TS_W | Reply delay in ticks |
| cfg_iters | input | CNT_W | Peer triggers after the first that complete a session |
| cfg_comp_lim | input | COMP_W-1 | Magnitude bound of the compensation value |
| now | input | TS_W | Current tick time |
| rx_valid | input | 1 | Peer trigger stamp valid |
| rx_ts | input | TS_W | Peer trigger stamp |
| lb_valid | input | 1 | Loopback stamp of own pulse valid |
| lb_ts | input | TS_W | Loopback stamp of own pulse |
| trig_out | output | 1 | Outgoing trigger pulse |
| done | output | 1 | Session complete strobe |
| err_out | output | TS_W | Signed local timing error |
| drift_out | output | TS_W+1 | Signed drift estimate toward the peer |

## Verification
The checks assume that `cfg_comp_lim` is not changed while a session is running, and that `cfg_iters` is at least 1. The bench writes all configuration before it raises `start` and never changes it inside a session. Loopback stamps are sent only after a pulse has been observed, apart from one deliberate stray stamp that exercises the ignore rule.

The stimulus covers three cases for the compensation value: a small lateness that passes through unchanged, a large lateness that is clamped, and a negative correction. It also covers the replacement of a pending target and a session placed so that `now` wraps.

// File: rtl/echo_pkg.sv
package echo_pkg;
  localparam int unsigned ECHO_TS_W   = 32;
  localparam int unsigned ECHO_CNT_W  = 16;
  localparam int unsigned ECHO_COMP_W = 16;
endpackage

// File: rtl/echo_comp.sv
// Lateness tracker: remembers the target of the last emission and turns the
// looped-back stamp of that emission into a bounded signed correction.
module echo_comp #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned COMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     fire,
  input  logic [TS_W-1:0]          fire_tgt,
  input  logic                     lb_valid,
  input  logic [TS_W-1:0]          lb_ts,
  input  logic [COMP_W-2:0]        lim,
  output logic signed [COMP_W-1:0] comp
);
  localparam int unsigned PAD_W = TS_W - COMP_W + 1;

  logic              await_q;
  logic [TS_W-1:0]   etgt_q;
  logic [TS_W-1:0]   diff;
  logic [TS_W-1:0]   mag;
  logic [TS_W-1:0]   lim_x;
  logic signed [COMP_W-1:0] sat;
  logic signed [COMP_W-1:0] comp_q;

  assign diff  = lb_ts - etgt_q;
  assign mag   = diff[TS_W-1] ? (~diff + 1'b1) : diff;
  assign lim_x = {{PAD_W{1'b0}}, lim};

  always_comb begin
    if (mag > lim_x) begin
      sat = diff[TS_W-1] ? -$signed({1'b0, lim}) : $signed({1'b0, lim});
    end else begin
      sat = $signed(diff[COMP_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      await_q <= 1'b0;
      etgt_q  <= '0;
      comp_q  <= '0;
    end else begin
      if (lb_valid && await_q) begin
        comp_q <= sat;
      end
      if (fire) begin
        await_q <= 1'b1;
        etgt_q  <= fire_tgt;
      end else if (lb_valid && await_q) begin
        await_q <= 1'b0;
      end
    end
  end

  assign comp = comp_q;
endmodule

// File: rtl/echo_sched.sv
// Emission scheduler: holds one pending target and fires a registered pulse
// once the tick time has reached it (wrap-safe signed distance).
module echo_sched #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned COMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     arm,
  input  logic [TS_W-1:0]          arm_ts,
  input  logic [TS_W-1:0]          delay,
  input  logic signed [COMP_W-1:0] comp,
  input  logic [TS_W-1:0]          now,
  output logic                     fire,
  output logic [TS_W-1:0]          tgt,
  output logic                     trig
);
  localparam int unsigned EXT_W = TS_W - COMP_W;

  logic            armed_q;
  logic            trig_q;
  logic [TS_W-1:0] tgt_q;
  logic [TS_W-1:0] comp_x;
  logic [TS_W-1:0] lead;

  assign comp_x = {{EXT_W{comp[COMP_W-1]}}, comp};
  assign lead   = now - tgt_q;
  assign fire   = armed_q && !arm && !lead[TS_W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      trig_q <= fire;
      if (arm) begin
        tgt_q   <= arm_ts + delay - comp_x;
        armed_q <= 1'b1;
      end else if (fire) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign tgt  = tgt_q;
  assign trig = trig_q;
endmodule

// File: rtl/echo_stats.sv
// Session bookkeeping: first stamp, iteration count, completion and error.
module echo_stats #(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   rx_valid,
  input  logic [TS_W-1:0]        rx_ts,
  input  logic [CNT_W-1:0]       iters,
  input  logic [TS_W-1:0]        delay,
  output logic                   arm,
  output logic                   done,
  output logic signed [TS_W-1:0] err,
  output logic signed [TS_W:0]   drift
);
  logic                   active_q;
  logic                   have_first_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [TS_W-1:0]        first_q;
  logic                   done_q;
  logic signed [TS_W-1:0] err_q;
  logic signed [TS_W:0]   drift_q;
  logic                   accept;
  logic                   last;
  logic [TS_W-1:0]        ideal;
  logic [TS_W-1:0]        span;

  assign accept = rx_valid && active_q;
  assign last   = accept && have_first_q &&
                  (({1'b0, cnt_q} + 1'b1) == {1'b0, iters});
  assign arm    = accept && !last;
  assign ideal  = (delay * TS_W'(iters)) << 1;
  assign span   = rx_ts - first_q - ideal;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q     <= 1'b0;
      have_first_q <= 1'b0;
      cnt_q        <= '0;
      first_q      <= '0;
      done_q       <= 1'b0;
      err_q        <= '0;
      drift_q      <= '0;
    end else if (start) begin
      active_q     <= 1'b1;
      have_first_q <= 1'b0;
      cnt_q        <= '0;
      done_q       <= 1'b0;
      err_q        <= '0;
      drift_q      <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        if (!have_first_q) begin
          first_q      <= rx_ts;
          have_first_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (last) begin
        active_q <= 1'b0;
        err_q    <= $signed(span);
        drift_q  <= $signed({span, 1'b0});
      end
    end
  end

  assign done  = done_q;
  assign err   = err_q;
  assign drift = drift_q;
endmodule

// File: rtl/echo_responder.sv
module echo_responder
  import echo_pkg::*;
#(
  parameter int unsigned TS_W   = ECHO_TS_W,
  parameter int unsigned CNT_W  = ECHO_CNT_W,
  parameter int unsigned COMP_W = ECHO_COMP_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [TS_W-1:0]        cfg_delay,
  input  logic [CNT_W-1:0]       cfg_iters,
  input  logic [COMP_W-2:0]      cfg_comp_lim,
  input  logic [TS_W-1:0]        now,
  input  logic                   rx_valid,
  input  logic [TS_W-1:0]        rx_ts,
  input  logic                   lb_valid,
  input  logic [TS_W-1:0]        lb_ts,
  output logic                   trig_out,
  output logic                   done,
  output logic signed [TS_W-1:0] err_out,
  output logic signed [TS_W:0]   drift_out
);
  logic                     arm;
  logic                     fire;
  logic [TS_W-1:0]          tgt;
  logic signed [COMP_W-1:0] comp_w;

  echo_stats #(.TS_W(TS_W), .CNT_W(CNT_W)) stats_i (
    .clk(clk), .rst(rst), .start(start),
    .rx_valid(rx_valid), .rx_ts(rx_ts),
    .iters(cfg_iters), .delay(cfg_delay),
    .arm(arm), .done(done), .err(err_out), .drift(drift_out)
  );

  echo_sched #(.TS_W(TS_W), .COMP_W(COMP_W)) sched_i (
    .clk(clk), .rst(rst), .clr(start),
    .arm(arm), .arm_ts(rx_ts), .delay(cfg_delay), .comp(comp_w),
    .now(now), .fire(fire), .tgt(tgt), .trig(trig_out)
  );

  echo_comp #(.TS_W(TS_W), .COMP_W(COMP_W)) comp_i (
    .clk(clk), .rst(rst), .clr(start),
    .fire(fire), .fire_tgt(tgt),
    .lb_valid(lb_valid), .lb_ts(lb_ts),
    .lim(cfg_comp_lim), .comp(comp_w)
  );
endmodule

// File: rtl/echo_responder_chk.sv
module echo_responder_chk #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned COMP_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start,
  input logic [COMP_W-2:0]        cfg_comp_lim,
  input logic                     trig_out,
  input logic                     done,
  input logic signed [TS_W-1:0]   err_out,
  input logic signed [COMP_W-1:0] comp_w
);
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
    start |=> (!trig_out && !done && comp_w == '0 && err_out == '0)); // R2

  AST_COMP_BOUND: assert property (@(posedge clk) disable iff (rst)
    ($signed(comp_w) <= $signed({1'b0, cfg_comp_lim})) &&
    ($signed(comp_w) >= -$signed({1'b0, cfg_comp_lim}))); // R5

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(err_out) |-> (done || $past(start))); // R7
endmodule

bind echo_responder echo_responder_chk #(.TS_W(TS_W), .COMP_W(COMP_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .cfg_comp_lim(cfg_comp_lim),
  .trig_out(trig_out), .done(done), .err_out(err_out), .comp_w(comp_w)
);

// File: tb/echo_responder_tb_top.sv
`timescale 1ns/1ps
module echo_responder_tb_top;
  localparam int TS_W = 32, CNT_W = 16, COMP_W = 16;
  localparam longint MASK = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, rx_valid = 1'b0, lb_valid = 1'b0;
  logic [TS_W-1:0] cfg_delay = 32'd20, rx_ts = '0, lb_ts = '0, now_r = 32'd1000;
  logic [CNT_W-1:0] cfg_iters = 16'd4;
  logic [COMP_W-2:0] cfg_lim = 15'd8;
  logic trig_out, done;
  logic signed [TS_W-1:0] err_out;
  logic signed [TS_W:0] drift_out;

  int checks = 0, errors = 0, trig_cnt = 0;
  bit finished = 0;
  longint last_trig_now = -1;

  always #2 clk = ~clk;

  echo_responder #(.TS_W(TS_W), .CNT_W(CNT_W), .COMP_W(COMP_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_delay(cfg_delay),
    .cfg_iters(cfg_iters), .cfg_comp_lim(cfg_lim), .now(now_r),
    .rx_valid(rx_valid), .rx_ts(rx_ts), .lb_valid(lb_valid), .lb_ts(lb_ts),
    .trig_out(trig_out), .done(done), .err_out(err_out), .drift_out(drift_out)
  );

  function automatic longint sx(longint v);
    longint w = v & MASK;
    if (w >= 64'h8000_0000) w = w - 64'h1_0000_0000;
    return w;
  endfunction

  // behavioural reference
  bit m_active, m_hf, m_armed, m_await, m_trig, m_done;
  int m_cnt;
  longint m_first, m_tgt, m_etgt, m_comp, m_err;

  always @(posedge clk) begin : model
    bit acc, fin;
    longint d, nc;
    if (rst) begin
      m_active = 0; m_hf = 0; m_armed = 0; m_await = 0; m_trig = 0; m_done = 0;
      m_cnt = 0; m_comp = 0; m_err = 0;
    end else if (start) begin
      m_active = 1; m_hf = 0; m_armed = 0; m_await = 0; m_trig = 0; m_done = 0;
      m_cnt = 0; m_comp = 0; m_err = 0;
    end else begin
      nc = m_comp;
      if (lb_valid && m_await) begin
        d = sx(longint'(lb_ts) - m_etgt);
        if (d > longint'(cfg_lim)) d = longint'(cfg_lim);
        if (d < -longint'(cfg_lim)) d = -longint'(cfg_lim);
        nc = d;
        m_await = 0;
      end
      acc = rx_valid && m_active;
      fin = acc && m_hf && (m_cnt + 1 == int'(cfg_iters));
      m_done = fin;
      m_trig = 0;
      if (acc) begin
        if (!m_hf) begin m_first = longint'(rx_ts); m_hf = 1; end
        else begin
          m_cnt++;
          if (fin) begin
            m_active = 0;
            m_err = sx(longint'(rx_ts) - m_first - 2 * longint'(cfg_iters) * longint'(cfg_delay));
          end
        end
      end
      if (acc && !fin) begin
        m_tgt = (longint'(rx_ts) + longint'(cfg_delay) - m_comp) & MASK;
        m_armed = 1;
      end else if (m_armed && sx(longint'(now_r) - m_tgt) >= 0) begin
        m_trig = 1; m_armed = 0; m_await = 1; m_etgt = m_tgt;
      end
      m_comp = nc;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit st, input bit rv, input longint rt, input bit lv, input longint lt);
    @(negedge clk);
    check(trig_out === m_trig, "R3 trig_out vs model", trig_out, m_trig);
    check(done === m_done, "R6 done vs model", done, m_done);
    check(longint'(err_out) == m_err, "R7 err_out vs model", err_out, m_err);
    check(longint'(drift_out) == 2 * m_err, "R7 drift_out vs model", drift_out, 2 * m_err);
    if (trig_out === 1'b1) begin
      last_trig_now = longint'(now_r);
      trig_cnt++;
    end
    start = st; rx_valid = rv; rx_ts = rt[TS_W-1:0]; lb_valid = lv; lb_ts = lt[TS_W-1:0];
    now_r = now_r + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  function automatic longint next_now(input longint off);
    return (longint'(now_r) + 1 + off) & MASK;
  endfunction

  initial begin : stim
    longint t1, t2, t3, t4, t5, tw, te;
    int base;
    repeat (3) @(negedge clk);
    check(trig_out == 0 && done == 0 && err_out == 0 && drift_out == 0, "R1 reset outputs", trig_out, 0);
    rst = 1'b0;
    // R1: inactive block ignores a peer trigger
    cyc(0, 1, next_now(0), 0, 0);
    idle(30);
    check(trig_cnt == 0, "R1 no echo before start", trig_cnt, 0);
    cyc(1, 0, 0, 0, 0);
    idle(1);
    check(trig_out == 0 && done == 0 && err_out == 0, "R2 cleared after start", err_out, 0);
    // A: reference trigger, comp 0
    t1 = next_now(0); cyc(0, 1, t1, 0, 0); idle(25);
    check(last_trig_now == ((t1 + 20) & MASK), "R3 emit at target", last_trig_now, t1 + 20);
    check(trig_cnt == 1, "R6 reference trigger echoed", trig_cnt, 1);
    cyc(0, 0, 0, 1, t1 + 23); idle(1);
    cyc(0, 0, 0, 1, t1 + 500);          // stray loopback, ignored
    // B: comp 3 expected
    t2 = next_now(-2); cyc(0, 1, t2, 0, 0); idle(25);
    check(last_trig_now == ((t2 + 17) & MASK), "R5 correction 3 and stray loopback ignored", last_trig_now, t2 + 17);
    cyc(0, 0, 0, 1, t2 + 17 + 50);       // saturates to 8
    // C: replacement of pending target
    base = trig_cnt;
    t3 = next_now(0); cyc(0, 1, t3, 0, 0); idle(3);
    t4 = next_now(0); cyc(0, 1, t4, 0, 0); idle(25);
    check(trig_cnt - base == 1, "R4 replaced target gives one pulse", trig_cnt - base, 1);
    check(last_trig_now == ((t4 + 12) & MASK), "R5 saturated correction", last_trig_now, t4 + 12);
    cyc(0, 0, 0, 1, t4 + 12 - 4);        // comp -4
    idle(2);
    // D: completion on fourth trigger after reference
    base = trig_cnt;
    t5 = next_now(0); cyc(0, 1, t5, 0, 0); idle(1);
    check(longint'(err_out) == sx(t5 - t1 - 160), "R7 error value", err_out, sx(t5 - t1 - 160));
    idle(25);
    cyc(0, 1, next_now(0), 0, 0); idle(25);
    check(trig_cnt == base, "R6 no echo after completion", trig_cnt - base, 0);
    check(longint'(err_out) == sx(t5 - t1 - 160), "R7 error held", err_out, sx(t5 - t1 - 160));
    // E: wrap of tick counter, iters = 1
    cfg_iters = 16'd1;
    now_r = 32'hFFFF_FFF0;
    cyc(1, 0, 0, 0, 0);
    tw = next_now(0); cyc(0, 1, tw, 0, 0); idle(30);
    check(last_trig_now == ((tw + 20) & MASK), "R8 emit across wrap", last_trig_now, (tw + 20) & MASK);
    cyc(0, 0, 0, 1, tw + 21);
    te = next_now(0); cyc(0, 1, te, 0, 0); idle(1);
    check(longint'(err_out) == sx(te - tw - 40), "R8 error across wrap", err_out, sx(te - tw - 40));
    check(longint'(drift_out) == 2 * sx(te - tw - 40), "R7 drift twice error", drift_out, 2 * sx(te - tw - 40));
    idle(5);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule